// File: doc/BRIEF.md
# MSI-X Vector Table and Pending-Bit Register File

This block stores the per-vector message state for a function that signals interrupts through MSI-X. Software reaches it through a small memory-mapped slave port. Each access carries a read or write strobe, a width select for 32-bit or 64-bit, an address and write data. The two top address bits choose one of three windows: the vector table, the pending-bit array, or the capability's message-control word. Read data comes back from a register one cycle after the strobe.

Interrupt logic uses a separate side port. It selects a vector and sees that vector's message address, message data, effective mask and pending bit as combinational outputs. Through the same port it can set or clear one pending bit per cycle. The global enable and the function mask are also brought out as level outputs.

The number of vectors is the parameter `NUM_VEC`, with an upper limit of 2048. The pending array holds `NUM_VEC/64 + 1` qwords of 64 bits each.

Top module: `msixrf_top`

## Requirements
- R1: After synchronous reset, every table field, every pending bit, the enable and the function mask read as zero, and `rsp_rdata` and `rsp_err` are zero.
- R2: The window code `req_addr[AW-1:AW-2]` selects the window: 2'b00 is the table, 2'b01 is the pending array, 2'b10 is the control word, and 2'b11 is unmapped. In the table window, the entry index is the offset divided by 16 and offset bits 3:2 pick the dword. Dword 0 is the low message address, dword 1 the high message address, dword 2 the message data and dword 3 vector control. A 32-bit read returns the dword in `rsp_rdata[31:0]` with the upper half zero.
- R3: A 64-bit table access at entry offset 0 covers {high address, low address}, and one at entry offset 8 covers {vector control, message data}, with the first-named field in bits 63:32. Writes split the same way.
- R4: Only bit 0 of vector control, the per-vector mask, is stored. Its other bits always read as zero.
- R5: Vector v's pending bit sits in qword v/64 at bit v%64, and qword q sits at pending-window offset 8q. A 64-bit read returns the whole qword. A 32-bit read at offset 0 returns bits 31:0, and one at offset 4 returns bits 63:32. On the side port, `pend_set` sets the bit of `pend_vec` and `pend_clr` clears it. When both are raised, set wins.
- R6: Software writes to the pending window change no pending bit and raise no error.
- R7: The control word is read as a 32-bit access at control-window offset 0 and lands in bits 15:0. Bit 15 is the enable, bit 14 the function mask, bits 10:0 hold `NUM_VEC-1`, and all other bits are zero. A write changes only bits 15 and 14.
- R8: An access is rejected if it is misaligned (32-bit not on 4 bytes, 64-bit not on 8 bytes), is 64-bit or at a nonzero offset in the control window, targets the unmapped window, or indexes past the last entry or qword. A rejected read returns zero and a rejected write changes nothing. In both cases `rsp_err` is high for exactly the one cycle after the strobe.
- R9: The side port outputs the selected vector's {high, low} message address, its message data and its pending bit. `vec_masked` is the vector's mask bit ORed with the function mask.
- R10: `rsp_rdata` is loaded on the clock edge that samples `req_rd` and keeps its value through cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_addr | input | AW | Byte address; top two bits select the window |
| req_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| rsp_rdata | output | 64 | Registered read data |
| rsp_err | output | 1 | One-cycle pulse for a rejected access |
| msix_enable | output | 1 | Enable bit of the control word |
| msix_fn_mask | output | 1 | Function mask bit of the control word |
| vec_sel | input | clog2(NUM_VEC) | Vector looked up on the side port |
| vec_msg_addr | output | 64 | Selected vector's message address |
| vec_msg_data | output | 32 | Selected vector's message data |
| vec_masked | output | 1 | Per-vector mask OR function mask |
| vec_pending | output | 1 | Selected vector's pending bit |
| pend_set | input | 1 | Set the pending bit of `pend_vec` |
| pend_clr | input | 1 | Clear the pending bit of `pend_vec` |
| pend_vec | input | clog2(NUM_VEC) | Vector whose pending bit is updated |

## Verification
The assertions assume that `req_rd` and `req_wr` are never raised in the same cycle, and one of them checks this. They also assume that side-port vector numbers below `NUM_VEC` are the ones that matter. The stimulus issues exactly one strobe per access, changes inputs only on the falling edge, and keeps `pend_set` and `pend_clr` low while it writes the pending window. This keeps the check that the pending bits stay unchanged under a software write free of interference from the side port.

// File: rtl/msixrf_pkg.sv
package msixrf_pkg;

    localparam int unsigned MAX_VECTORS = 2048;
    localparam int unsigned QWORD_BITS  = 64;
    localparam int unsigned CTRL_EN_POS = 15;
    localparam int unsigned CTRL_FM_POS = 14;

    typedef enum logic [1:0] {
        WIN_TABLE = 2'b00,
        WIN_PBA   = 2'b01,
        WIN_CTRL  = 2'b10,
        WIN_NONE  = 2'b11
    } win_e;

    typedef enum logic [1:0] {
        DW_ADDR_LO = 2'd0,
        DW_ADDR_HI = 2'd1,
        DW_DATA    = 2'd2,
        DW_VCTL    = 2'd3
    } dword_e;

    typedef struct packed {
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        mask;
    } entry_t;

    typedef struct packed {
        win_e   win;
        logic   ok;
        logic   wide;
        dword_e dw;
        logic   hi_half;
    } dec_t;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned pba_qwords(input int unsigned n);
        return n / QWORD_BITS + 1;
    endfunction

    function automatic logic [15:0] ctrl_word(input logic en, input logic fm,
                                              input int unsigned n);
        logic [15:0] w;
        w = '0;
        w[CTRL_EN_POS] = en;
        w[CTRL_FM_POS] = fm;
        w[10:0]        = 11'(n - 1);
        return w;
    endfunction

endpackage

// File: rtl/msixrf_decode.sv
module msixrf_decode
    import msixrf_pkg::*;
#(
    parameter int unsigned NUM_VEC = 16,
    parameter int unsigned AW      = 16
) (
    input  logic [AW-1:0]                                  addr,
    input  logic                                           wide,
    output dec_t                                           dec,
    output logic [idx_bits(NUM_VEC)-1:0]                   ent_idx,
    output logic [idx_bits(pba_qwords(NUM_VEC))-1:0]       qw_idx
);
    localparam int unsigned OW  = AW - 2;
    localparam int unsigned IW  = idx_bits(NUM_VEC);
    localparam int unsigned NQW = pba_qwords(NUM_VEC);
    localparam int unsigned QW  = idx_bits(NQW);

    logic [OW-1:0] off;
    logic [OW-5:0] ent_full;
    logic [OW-4:0] qw_full;
    logic          al4;
    logic          al8;
    win_e          win;

    assign off      = addr[OW-1:0];
    assign ent_full = off[OW-1:4];
    assign qw_full  = off[OW-1:3];
    assign al4      = (off[1:0] == 2'b00);
    assign al8      = (off[2:0] == 3'b000);
    assign win      = win_e'(addr[AW-1:OW]);

    always_comb begin
        dec.win     = win;
        dec.wide    = wide;
        dec.dw      = dword_e'(off[3:2]);
        dec.hi_half = off[2];
        dec.ok      = 1'b0;
        ent_idx     = IW'(ent_full);
        qw_idx      = QW'(qw_full);
        case (win)
            WIN_TABLE: dec.ok = (wide ? al8 : al4) && (32'(ent_full) < NUM_VEC);
            WIN_PBA:   dec.ok = (wide ? al8 : al4) && (32'(qw_full) < NQW);
            WIN_CTRL:  dec.ok = !wide && (off == '0);
            default:   dec.ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/msixrf_table.sv
module msixrf_table
    import msixrf_pkg::*;
#(
    parameter int unsigned NUM_VEC = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          wide,
    input  dword_e                        dw,
    input  logic [idx_bits(NUM_VEC)-1:0]  acc_idx,
    input  logic [63:0]                   wdata,
    output logic [63:0]                   acc_rdata,
    input  logic [idx_bits(NUM_VEC)-1:0]  side_idx,
    output entry_t                        side_ent
);
    localparam int unsigned IW = idx_bits(NUM_VEC);

    entry_t ents [NUM_VEC];
    entry_t acc_ent;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
        entry_t ent_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (wr_en && acc_idx == IW'(g)) begin
                if (wide) begin
                    if (dw == DW_ADDR_LO) begin
                        ent_q.addr_lo <= wdata[31:0];
                        ent_q.addr_hi <= wdata[63:32];
                    end else begin
                        ent_q.data <= wdata[31:0];
                        ent_q.mask <= wdata[32];
                    end
                end else begin
                    case (dw)
                        DW_ADDR_LO: ent_q.addr_lo <= wdata[31:0];
                        DW_ADDR_HI: ent_q.addr_hi <= wdata[31:0];
                        DW_DATA:    ent_q.data    <= wdata[31:0];
                        default:    ent_q.mask    <= wdata[0];
                    endcase
                end
            end
        end
        assign ents[g] = ent_q;
    end

    always_comb begin
        acc_ent  = '0;
        side_ent = '0;
        for (int k = 0; k < NUM_VEC; k++) begin
            if (int'(acc_idx) == k)  acc_ent  = ents[k];
            if (int'(side_idx) == k) side_ent = ents[k];
        end
    end

    always_comb begin
        if (wide) begin
            if (dw == DW_ADDR_LO) acc_rdata = {acc_ent.addr_hi, acc_ent.addr_lo};
            else                  acc_rdata = {31'd0, acc_ent.mask, acc_ent.data};
        end else begin
            case (dw)
                DW_ADDR_LO: acc_rdata = {32'd0, acc_ent.addr_lo};
                DW_ADDR_HI: acc_rdata = {32'd0, acc_ent.addr_hi};
                DW_DATA:    acc_rdata = {32'd0, acc_ent.data};
                default:    acc_rdata = {63'd0, acc_ent.mask};
            endcase
        end
    end

endmodule

// File: rtl/msixrf_pba.sv
module msixrf_pba
    import msixrf_pkg::*;
#(
    parameter int unsigned NUM_VEC = 16
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      set,
    input  logic                                      clr,
    input  logic [idx_bits(NUM_VEC)-1:0]              vec,
    input  logic [idx_bits(pba_qwords(NUM_VEC))-1:0]  qsel,
    output logic [63:0]                               qword,
    output logic [NUM_VEC-1:0]                        bits
);
    localparam int unsigned IW  = idx_bits(NUM_VEC);
    localparam int unsigned NQW = pba_qwords(NUM_VEC);

    logic [NQW*QWORD_BITS-1:0] pad;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)                             bit_q <= 1'b0;
            else if (set && vec == IW'(g))       bit_q <= 1'b1;
            else if (clr && vec == IW'(g))       bit_q <= 1'b0;
        end
        assign bits[g] = bit_q;
    end

    always_comb begin
        pad              = '0;
        pad[NUM_VEC-1:0] = bits;
        qword            = '0;
        for (int k = 0; k < NQW; k++) begin
            if (int'(qsel) == k) qword = pad[k*QWORD_BITS +: QWORD_BITS];
        end
    end

    // R5: side-port set lands in the addressed bit, and set wins over clear
    a_r5_set_lands: assert property (@(posedge clk) disable iff (rst)
        (set && int'(vec) < NUM_VEC) |=> (bits[$past(vec)] == 1'b1));

    // R5: a lone clear removes the addressed bit
    a_r5_clr_lands: assert property (@(posedge clk) disable iff (rst)
        (clr && !set && int'(vec) < NUM_VEC) |=> (bits[$past(vec)] == 1'b0));

endmodule

// File: rtl/msixrf_top.sv
module msixrf_top
    import msixrf_pkg::*;
#(
    parameter int unsigned NUM_VEC = 16,
    parameter int unsigned AW      = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_rd,
    input  logic                          req_wr,
    input  logic                          req_wide,
    input  logic [AW-1:0]                 req_addr,
    input  logic [63:0]                   req_wdata,
    output logic [63:0]                   rsp_rdata,
    output logic                          rsp_err,
    output logic                          msix_enable,
    output logic                          msix_fn_mask,
    input  logic [idx_bits(NUM_VEC)-1:0]  vec_sel,
    output logic [63:0]                   vec_msg_addr,
    output logic [31:0]                   vec_msg_data,
    output logic                          vec_masked,
    output logic                          vec_pending,
    input  logic                          pend_set,
    input  logic                          pend_clr,
    input  logic [idx_bits(NUM_VEC)-1:0]  pend_vec
);
    localparam int unsigned IW  = idx_bits(NUM_VEC);
    localparam int unsigned NQW = pba_qwords(NUM_VEC);
    localparam int unsigned QW  = idx_bits(NQW);

    dec_t          dec;
    logic [IW-1:0] ent_idx;
    logic [QW-1:0] qw_idx;
    logic [63:0]   tab_rdata;
    logic [63:0]   pba_q;
    logic [NUM_VEC-1:0] pend_bits;
    entry_t        side_ent;
    logic          wr_tab;
    logic          wr_ctl;
    logic          bad;
    logic          en_q;
    logic          fm_q;
    logic [63:0]   rd_next;

    msixrf_decode #(.NUM_VEC(NUM_VEC), .AW(AW)) u_dec (
        .addr    (req_addr),
        .wide    (req_wide),
        .dec     (dec),
        .ent_idx (ent_idx),
        .qw_idx  (qw_idx)
    );

    assign wr_tab = req_wr && dec.ok && (dec.win == WIN_TABLE);
    assign wr_ctl = req_wr && dec.ok && (dec.win == WIN_CTRL);
    assign bad    = (req_rd || req_wr) && !dec.ok;

    msixrf_table #(.NUM_VEC(NUM_VEC)) u_tab (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_tab),
        .wide      (req_wide),
        .dw        (dec.dw),
        .acc_idx   (ent_idx),
        .wdata     (req_wdata),
        .acc_rdata (tab_rdata),
        .side_idx  (vec_sel),
        .side_ent  (side_ent)
    );

    msixrf_pba #(.NUM_VEC(NUM_VEC)) u_pba (
        .clk   (clk),
        .rst   (rst),
        .set   (pend_set),
        .clr   (pend_clr),
        .vec   (pend_vec),
        .qsel  (qw_idx),
        .qword (pba_q),
        .bits  (pend_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            fm_q <= 1'b0;
        end else if (wr_ctl) begin
            en_q <= req_wdata[CTRL_EN_POS];
            fm_q <= req_wdata[CTRL_FM_POS];
        end
    end

    always_comb begin
        rd_next = '0;
        if (dec.ok) begin
            case (dec.win)
                WIN_TABLE: rd_next = tab_rdata;
                WIN_PBA: begin
                    if (req_wide)         rd_next = pba_q;
                    else if (dec.hi_half) rd_next = {32'd0, pba_q[63:32]};
                    else                  rd_next = {32'd0, pba_q[31:0]};
                end
                WIN_CTRL:  rd_next = {48'd0, ctrl_word(en_q, fm_q, NUM_VEC)};
                default:   rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_err <= bad;
            if (req_rd) rsp_rdata <= rd_next;
        end
    end

    assign msix_enable  = en_q;
    assign msix_fn_mask = fm_q;
    assign vec_msg_addr = {side_ent.addr_hi, side_ent.addr_lo};
    assign vec_msg_data = side_ent.data;
    assign vec_masked   = side_ent.mask | fm_q;

    always_comb begin
        vec_pending = 1'b0;
        for (int k = 0; k < NUM_VEC; k++) begin
            if (int'(vec_sel) == k) vec_pending = pend_bits[k];
        end
    end

    // R2: one strobe per cycle is expected from the requester
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(req_rd && req_wr));

    // R4: vector-control dword never shows bits above the mask
    a_r4_vctl_bit0_only: assert property (@(posedge clk) disable iff (rst)
        (req_rd && dec.ok && dec.win == WIN_TABLE && !req_wide && dec.dw == DW_VCTL)
        |=> (rsp_rdata[63:1] == 63'd0));

    // R6: a software write to the pending window leaves every pending bit alone
    a_r6_pba_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_wr && dec.win == WIN_PBA && !pend_set && !pend_clr) |=> $stable(pend_bits));

    // R7: enable and function mask move only on a write
    a_r7_ctrl_needs_write: assert property (@(posedge clk) disable iff (rst)
        !req_wr |=> ($stable(msix_enable) && $stable(msix_fn_mask)));

    // R8: a rejected read returns zero and flags the error
    a_r8_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
        (req_rd && !dec.ok) |=> (rsp_rdata == 64'd0 && rsp_err));

    // R8: no strobe, no error pulse
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
        (!req_rd && !req_wr) |=> !rsp_err);

    // R10: read data holds without a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !req_rd |=> $stable(rsp_rdata));

endmodule

// File: tb/tb_msixrf_top.sv
module tb_msixrf_top;
    import msixrf_pkg::*;

    localparam int unsigned NV_DUT = 72;
    localparam int unsigned AW     = 16;
    localparam int unsigned IW     = idx_bits(NV_DUT);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_rd = 1'b0, req_wr = 1'b0, req_wide = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [63:0]     req_wdata = '0;
    logic [63:0]     rsp_rdata;
    logic            rsp_err;
    logic            msix_enable, msix_fn_mask;
    logic [IW-1:0]   vec_sel = '0;
    logic [63:0]     vec_msg_addr;
    logic [31:0]     vec_msg_data;
    logic            vec_masked, vec_pending;
    logic            pend_set = 1'b0, pend_clr = 1'b0;
    logic [IW-1:0]   pend_vec = '0;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    msixrf_top #(.NUM_VEC(NV_DUT), .AW(AW)) dut (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .msix_enable(msix_enable), .msix_fn_mask(msix_fn_mask),
        .vec_sel(vec_sel), .vec_msg_addr(vec_msg_addr), .vec_msg_data(vec_msg_data),
        .vec_masked(vec_masked), .vec_pending(vec_pending), .pend_set(pend_set),
        .pend_clr(pend_clr), .pend_vec(pend_vec)
    );

    typedef struct packed {
        logic        wr;
        logic        wide;
        logic [15:0] addr;
        logic [63:0] wd;
        logic [63:0] exp;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 16'h0010, 64'h0000_0000_1111_2222, 64'h0, 1'b0, 8'd2},  // R2 write dword 0
        '{1'b1, 1'b0, 16'h0014, 64'h0000_0000_3333_4444, 64'h0, 1'b0, 8'd2},  // R2 write dword 1
        '{1'b1, 1'b0, 16'h0018, 64'h0000_0000_5555_6666, 64'h0, 1'b0, 8'd2},  // R2 write dword 2
        '{1'b1, 1'b0, 16'h001C, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 8'd4},  // R4 write vctl
        '{1'b0, 1'b0, 16'h0010, 64'h0, 64'h0000_0000_1111_2222, 1'b0, 8'd2}, // R2
        '{1'b0, 1'b0, 16'h0014, 64'h0, 64'h0000_0000_3333_4444, 1'b0, 8'd2}, // R2
        '{1'b0, 1'b0, 16'h0018, 64'h0, 64'h0000_0000_5555_6666, 1'b0, 8'd2}, // R2
        '{1'b0, 1'b0, 16'h001C, 64'h0, 64'h0000_0000_0000_0001, 1'b0, 8'd4}, // R4
        '{1'b0, 1'b1, 16'h0010, 64'h0, 64'h3333_4444_1111_2222, 1'b0, 8'd3}, // R3
        '{1'b0, 1'b1, 16'h0018, 64'h0, 64'h0000_0001_5555_6666, 1'b0, 8'd3}, // R3
        '{1'b1, 1'b1, 16'h00F0, 64'hAAAA_0000_BBBB_0000, 64'h0, 1'b0, 8'd3},  // R3 wide write addr
        '{1'b1, 1'b1, 16'h00F8, 64'h0000_0002_CCCC_0000, 64'h0, 1'b0, 8'd4},  // R4 bit 33 dropped
        '{1'b0, 1'b0, 16'h00F4, 64'h0, 64'h0000_0000_AAAA_0000, 1'b0, 8'd3}, // R3
        '{1'b0, 1'b0, 16'h00F0, 64'h0, 64'h0000_0000_BBBB_0000, 1'b0, 8'd3}, // R3
        '{1'b0, 1'b1, 16'h00F8, 64'h0, 64'h0000_0000_CCCC_0000, 1'b0, 8'd4}, // R4
        '{1'b0, 1'b0, 16'h0012, 64'h0, 64'h0, 1'b1, 8'd8},                   // R8 misaligned
        '{1'b0, 1'b1, 16'h0014, 64'h0, 64'h0, 1'b1, 8'd8},                   // R8 wide on 4
        '{1'b1, 1'b0, 16'h0011, 64'h0000_0000_0000_DEAD, 64'h0, 1'b1, 8'd8},  // R8 bad write
        '{1'b0, 1'b0, 16'h0010, 64'h0, 64'h0000_0000_1111_2222, 1'b0, 8'd8}, // R8 no effect
        '{1'b0, 1'b0, 16'h0480, 64'h0, 64'h0, 1'b1, 8'd8},                   // R8 entry 72
        '{1'b0, 1'b0, 16'h8000, 64'h0, 64'h0000_0000_0000_0047, 1'b0, 8'd1}, // R1 ctrl reset
        '{1'b1, 1'b0, 16'h8000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 8'd7},  // R7
        '{1'b0, 1'b0, 16'h8000, 64'h0, 64'h0000_0000_0000_C047, 1'b0, 8'd7}, // R7
        '{1'b0, 1'b1, 16'h8000, 64'h0, 64'h0, 1'b1, 8'd8},                   // R8 wide ctrl
        '{1'b0, 1'b0, 16'h8004, 64'h0, 64'h0, 1'b1, 8'd8},                   // R8 ctrl offset
        '{1'b0, 1'b0, 16'hC000, 64'h0, 64'h0, 1'b1, 8'd8},                   // R8 unmapped
        '{1'b1, 1'b0, 16'h8000, 64'h0000_0000_0000_4000, 64'h0, 1'b0, 8'd7},  // R7
        '{1'b0, 1'b0, 16'h8000, 64'h0, 64'h0000_0000_0000_4047, 1'b0, 8'd7}, // R7
        '{1'b0, 1'b1, 16'h4000, 64'h0, 64'h0, 1'b0, 8'd1},                   // R1 pending reset
        '{1'b0, 1'b0, 16'h4010, 64'h0, 64'h0, 1'b1, 8'd8}                    // R8 qword 2
    };

    task automatic check(input int r, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic op(input logic wr, input logic wide, input logic [15:0] a,
                      input logic [63:0] wd, output logic [63:0] rd, output logic er);
        @(negedge clk);
        req_rd = !wr; req_wr = wr; req_wide = wide; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
        rd = rsp_rdata; er = rsp_err;
    endtask

    task automatic pend(input logic s, input logic c, input int v);
        @(negedge clk);
        pend_set = s; pend_clr = c; pend_vec = IW'(v);
        @(negedge clk);
        pend_set = 1'b0; pend_clr = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL R10: watchdog actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic        er;
        logic [63:0] held;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state at the ports
        check(1, rsp_rdata, 64'd0);
        check(1, {63'd0, rsp_err}, 64'd0);
        check(1, {62'd0, msix_enable, msix_fn_mask}, 64'd0);
        op(1'b0, 1'b1, 16'h0000, 64'd0, rd, er); check(1, rd, 64'd0);
        op(1'b0, 1'b1, 16'h0008, 64'd0, rd, er); check(1, rd, 64'd0);
        op(1'b0, 1'b1, 16'h4008, 64'd0, rd, er); check(1, rd, 64'd0);

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].wr, VECS[i].wide, VECS[i].addr, VECS[i].wd, rd, er);
            if (!VECS[i].wr) check(int'(VECS[i].req), rd, VECS[i].exp);
            check(int'(VECS[i].req), {63'd0, er}, {63'd0, VECS[i].err});
        end

        // R8: error is a single-cycle pulse
        op(1'b0, 1'b0, 16'h0013, 64'd0, rd, er);
        check(8, {63'd0, er}, 64'd1);
        @(negedge clk);
        check(8, {63'd0, rsp_err}, 64'd0);

        // R5: side-port set/clear and qword/half placement
        pend(1'b1, 1'b0, 3);
        pend(1'b1, 1'b0, 40);
        pend(1'b1, 1'b0, 70);
        pend(1'b1, 1'b1, 5);   // set wins
        op(1'b0, 1'b1, 16'h4000, 64'd0, rd, er);
        check(5, rd, 64'h0000_0100_0000_0028);
        op(1'b0, 1'b0, 16'h4000, 64'd0, rd, er); check(5, rd, 64'h0000_0000_0000_0028);
        op(1'b0, 1'b0, 16'h4004, 64'd0, rd, er); check(5, rd, 64'h0000_0000_0000_0100);
        op(1'b0, 1'b1, 16'h4008, 64'd0, rd, er); check(5, rd, 64'h0000_0000_0000_0040);
        pend(1'b0, 1'b1, 40);
        op(1'b0, 1'b0, 16'h4004, 64'd0, rd, er); check(5, rd, 64'd0);

        // R6: software write to pending window is ignored without error
        op(1'b1, 1'b1, 16'h4000, 64'hFFFF_FFFF_FFFF_FFFF, rd, er);
        check(6, {63'd0, er}, 64'd0);
        op(1'b1, 1'b0, 16'h4000, 64'd0, rd, er);
        op(1'b0, 1'b1, 16'h4000, 64'd0, rd, er); check(6, rd, 64'h0000_0000_0000_0028);

        // R9: side-port lookup; function mask is currently set
        @(negedge clk); vec_sel = IW'(1); #1;
        check(9, vec_msg_addr, 64'h3333_4444_1111_2222);
        check(9, {32'd0, vec_msg_data}, 64'h0000_0000_5555_6666);
        check(9, {63'd0, vec_masked}, 64'd1);
        vec_sel = IW'(15); #1;
        check(9, {63'd0, vec_masked}, 64'd1);
        op(1'b1, 1'b0, 16'h8000, 64'h0000_0000_0000_8000, rd, er);
        #1;
        check(9, {63'd0, vec_masked}, 64'd0);
        check(7, {62'd0, msix_enable, msix_fn_mask}, 64'd2);
        vec_sel = IW'(3); #1;
        check(9, {63'd0, vec_pending}, 64'd1);
        vec_sel = IW'(40); #1;
        check(9, {63'd0, vec_pending}, 64'd0);

        // R10: read data holds across idle cycles and writes
        op(1'b0, 1'b0, 16'h0014, 64'd0, held, er);
        repeat (3) @(negedge clk);
        check(10, rsp_rdata, held);
        op(1'b1, 1'b0, 16'h0020, 64'h0000_0000_9999_0000, rd, er);
        check(10, rd, held);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule